// File: doc/BRIEF.md
# Serial Sampling Converter Control Core

This block is the digital heart of an 8-bit successive-approximation converter that is read over a two-wire serial link: an active-low select and an externally driven I/O clock. Both lines arrive asynchronously. They are brought into the free-running system clock domain, and the select line is filtered against short noise pulses. While the part is selected, the result of the previous conversion is shifted out MSB first on a data pin that is released whenever select is high.

The same eight I/O clock falling edges that read out the old result also run the next conversion. The sampling window opens at the fourth falling edge. The eighth falling edge freezes the input and starts a fixed sequence on the system clock: a short hold phase, then one trial per result bit, MSB first. The trial word is presented on a port for an external behavioural comparator. In test mode the decisions come instead from a code register input. A new recognised select, or a new complete frame, cancels a conversion that is still running.

Top module: `sadc_serial_ctrl`

## Requirements
- R1: While the select pin is high the data pin is not driven, and I/O clock edges change neither the frame position, the sampling strobe nor the conversion state.
- R2: A select low is recognised only after the synchronised select has been low for CS_FILT (default 3) consecutive system clocks. A shorter low pulse has no effect and does not cancel a running conversion.
- R3: A rising select releases the data pin in the same cycle, combinationally, before the filtered logic sees the change.
- R4: On recognition the MSB of the stored result is driven. Each of the next seven accepted I/O clock falling edges moves the pin one bit toward the LSB.
- R5: sampleEn goes high on the 4th accepted falling edge of a frame and low on the 8th.
- R6: The 8th falling edge starts hold. holdEn is high for HOLD_CYC (4) system clocks. Then come RES_W*CYC_PER_BIT (32) conversion cycles, one result bit per CYC_PER_BIT cycles, MSB first. The trial word (decided bits plus the current bit set) appears on sarTrial during conversion and is zero otherwise.
- R7: With testSel=1 a trial bit is kept when the trial word is less than or equal to testCode, so the result equals testCode. With testSel=0 a trial bit is kept when cmpIn is 1.
- R8: The stored result changes only at the end of the final conversion cycle. convDone is high for exactly that one system clock.
- R9: A recognised select, or another 8th falling edge, cancels the running conversion, even in its final cycle. The stored result keeps its earlier value and no convDone is raised for the cancelled conversion.
- R10: With select held low, every 8 accepted falling edges form a frame. The next frame starts from the stored result. If a conversion completes while no edge of the next frame has yet been taken, the pin reloads with the new result.
- R11: After reset the stored result is 0x00, the frame position is cleared, the data pin is released, and sampleEn, holdEn and convDone are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running system clock |
| rstN | input | 1 | Asynchronous active-low reset |
| csN | input | 1 | Asynchronous active-low select |
| ioClk | input | 1 | Asynchronous serial I/O clock |
| cmpIn | input | 1 | Comparator decision: 1 keeps the current trial bit |
| testSel | input | 1 | 1 takes decisions from testCode instead of cmpIn |
| testCode | input | RES_W | Test code the conversion converges to in test mode |
| serData | output | 1 | Serial result, high impedance when not driven |
| serDrive | output | 1 | High while serData is driven |
| sarTrial | output | RES_W | Current trial word for the comparator |
| sampleEn | output | 1 | Input sampling window |
| holdEn | output | 1 | Hold phase strobe |
| convDone | output | 1 | One-cycle pulse when a result is stored |

## Verification
The closest coincidences are a frame ending while a conversion is still counting, and a completion landing in a cycle where the select filter or a new falling edge also acts. The bench provokes the first with a fast third frame issued right after a slow second one while select stays low. It provokes the second with a quick deselect and reselect right after a frame. A per-clock behavioural model decides which event wins each cycle. The convDone count and the value read out on the next frame must show that the cancelled conversion left no trace.

// File: rtl/sadc_pkg.sv
package sadc_pkg;

  // Wide enough for the bit index of any supported resolution (up to 16 bits).
  localparam int IDX_W = 4;

  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_HOLD = 2'd1,
    PH_CONV = 2'd2
  } phase_t;

  // Strobes from the control sequencer to the datapath.
  typedef struct packed {
    logic             loadShift;  // load output shifter from the result
    logic             shiftOut;   // advance output shifter one bit
    logic             refresh;    // reload shifter with a fresh result
    logic             clearSar;   // clear the approximation register
    logic             decide;     // take the comparator decision this cycle
    logic             commit;     // store the finished result
    logic             trialOn;    // conversion phase active
    logic [IDX_W-1:0] bitIdx;     // bit under trial
  } strobe_t;

endpackage

// File: rtl/sadc_sync.sv
module sadc_sync #(
  parameter int   STAGES    = 2,
  parameter logic RESET_VAL = 1'b0
) (
  input  logic clk,
  input  logic rstN,
  input  logic d,
  output logic q
);

  logic [STAGES-1:0] stg;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) stg <= {STAGES{RESET_VAL}};
    else       stg <= {stg[STAGES-2:0], d};
  end

  assign q = stg[STAGES-1];

endmodule

// File: rtl/sadc_ctl.sv
module sadc_ctl
  import sadc_pkg::*;
#(
  parameter int RES_W       = 8,
  parameter int HOLD_CYC    = 4,
  parameter int CYC_PER_BIT = 4,
  parameter int CS_FILT     = 3,
  parameter int SYNC_STAGES = 2
) (
  input  logic    clk,
  input  logic    rstN,
  input  logic    csN,
  input  logic    ioClk,
  output strobe_t stb,
  output logic    csActive,
  output logic    sampleEn,
  output logic    holdEn
);

  localparam int CONV_CYC  = RES_W * CYC_PER_BIT;
  localparam int CNT_W     = $clog2(CONV_CYC > HOLD_CYC ? CONV_CYC : HOLD_CYC) + 1;
  localparam int EDGE_W    = $clog2(RES_W);
  localparam int FILT_W    = $clog2(CS_FILT) + 1;
  localparam int SAMPLE_AT = RES_W / 2;

  logic csSync, ioSync, ioPrev, ioFall;
  logic [FILT_W-1:0] filtCnt;
  logic [EDGE_W-1:0] edgeCnt;
  logic [CNT_W-1:0]  phCnt;
  phase_t            phase;

  logic csStart, fallOk, frameEnd, abortConv, lastHold, lastConv, slotEnd;

  sadc_sync #(.STAGES(SYNC_STAGES), .RESET_VAL(1'b1)) csSyncI (
    .clk(clk), .rstN(rstN), .d(csN), .q(csSync)
  );
  sadc_sync #(.STAGES(SYNC_STAGES), .RESET_VAL(1'b0)) ioSyncI (
    .clk(clk), .rstN(rstN), .d(ioClk), .q(ioSync)
  );

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) ioPrev <= 1'b0;
    else       ioPrev <= ioSync;
  end

  assign ioFall    = ioPrev & ~ioSync;
  assign csStart   = ~csSync & ~csActive & (filtCnt == FILT_W'(CS_FILT - 1));
  assign fallOk    = ~csSync & csActive & ioFall;
  assign frameEnd  = fallOk & (edgeCnt == EDGE_W'(RES_W - 1));
  assign abortConv = csStart | frameEnd;
  assign lastHold  = (phase == PH_HOLD) && (phCnt == CNT_W'(HOLD_CYC - 1));
  assign lastConv  = (phase == PH_CONV) && (phCnt == CNT_W'(CONV_CYC - 1));
  assign slotEnd   = (phCnt % CNT_W'(CYC_PER_BIT)) == CNT_W'(CYC_PER_BIT - 1);

  // Select filter and frame position
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      csActive <= 1'b0;
      filtCnt  <= '0;
      edgeCnt  <= '0;
      sampleEn <= 1'b0;
    end else if (csSync) begin
      csActive <= 1'b0;
      filtCnt  <= '0;
      edgeCnt  <= '0;
      sampleEn <= 1'b0;
    end else if (!csActive) begin
      if (csStart) begin
        csActive <= 1'b1;
        edgeCnt  <= '0;
        sampleEn <= 1'b0;
      end else begin
        filtCnt <= filtCnt + FILT_W'(1);
      end
    end else if (ioFall) begin
      if (frameEnd) begin
        edgeCnt  <= '0;
        sampleEn <= 1'b0;
      end else begin
        edgeCnt <= edgeCnt + EDGE_W'(1);
        if (edgeCnt == EDGE_W'(SAMPLE_AT - 1)) sampleEn <= 1'b1;
      end
    end
  end

  // Hold and conversion sequencer
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      phase <= PH_IDLE;
      phCnt <= '0;
    end else if (abortConv) begin
      phase <= frameEnd ? PH_HOLD : PH_IDLE;
      phCnt <= '0;
    end else begin
      unique case (phase)
        PH_HOLD: begin
          if (lastHold) begin
            phase <= PH_CONV;
            phCnt <= '0;
          end else begin
            phCnt <= phCnt + CNT_W'(1);
          end
        end
        PH_CONV: begin
          if (lastConv) begin
            phase <= PH_IDLE;
            phCnt <= '0;
          end else begin
            phCnt <= phCnt + CNT_W'(1);
          end
        end
        default: phCnt <= '0;
      endcase
    end
  end

  assign holdEn = (phase == PH_HOLD);

  always_comb begin
    stb           = '0;
    stb.loadShift = csStart | frameEnd;
    stb.shiftOut  = fallOk & ~frameEnd;
    stb.clearSar  = frameEnd;
    stb.trialOn   = (phase == PH_CONV);
    stb.decide    = (phase == PH_CONV) & slotEnd & ~abortConv;
    stb.commit    = lastConv & ~abortConv;
    stb.refresh   = lastConv & ~abortConv & csActive & ~csSync & ~fallOk
                    & (edgeCnt == '0);
    stb.bitIdx    = IDX_W'(RES_W - 1) - IDX_W'(phCnt / CNT_W'(CYC_PER_BIT));
  end

endmodule

// File: rtl/sadc_dp.sv
module sadc_dp
  import sadc_pkg::*;
#(
  parameter int RES_W = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  strobe_t          stb,
  input  logic             cmpIn,
  input  logic             testSel,
  input  logic [RES_W-1:0] testCode,
  output logic             serBit,
  output logic [RES_W-1:0] sarTrial,
  output logic             convDone
);

  logic [RES_W-1:0] shiftQ, sarQ, resultQ;
  logic [RES_W-1:0] bitMask, trialWord, sarNext, resultNext;
  logic             keepBit;

  assign bitMask    = RES_W'(1) << stb.bitIdx;
  assign trialWord  = sarQ | bitMask;
  assign keepBit    = testSel ? (trialWord <= testCode) : cmpIn;
  assign sarNext    = keepBit ? trialWord : sarQ;
  assign resultNext = stb.commit ? sarNext : resultQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)             sarQ <= '0;
    else if (stb.clearSar) sarQ <= '0;
    else if (stb.decide)   sarQ <= sarNext;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      resultQ  <= '0;
      convDone <= 1'b0;
    end else begin
      resultQ  <= resultNext;
      convDone <= stb.commit;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)              shiftQ <= '0;
    else if (stb.loadShift) shiftQ <= resultNext;
    else if (stb.shiftOut)  shiftQ <= {shiftQ[RES_W-2:0], 1'b0};
    else if (stb.refresh)   shiftQ <= resultNext;
  end

  assign serBit   = shiftQ[RES_W-1];
  assign sarTrial = stb.trialOn ? trialWord : '0;

endmodule

// File: rtl/sadc_serial_ctrl.sv
module sadc_serial_ctrl
  import sadc_pkg::*;
#(
  parameter int RES_W       = 8,
  parameter int HOLD_CYC    = 4,
  parameter int CYC_PER_BIT = 4,
  parameter int CS_FILT     = 3,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             csN,
  input  logic             ioClk,
  input  logic             cmpIn,
  input  logic             testSel,
  input  logic [RES_W-1:0] testCode,
  output logic             serData,
  output logic             serDrive,
  output logic [RES_W-1:0] sarTrial,
  output logic             sampleEn,
  output logic             holdEn,
  output logic             convDone
);

  strobe_t stb;
  logic    csActive;
  logic    serBit;

  sadc_ctl #(
    .RES_W(RES_W), .HOLD_CYC(HOLD_CYC), .CYC_PER_BIT(CYC_PER_BIT),
    .CS_FILT(CS_FILT), .SYNC_STAGES(SYNC_STAGES)
  ) ctlI (
    .clk(clk), .rstN(rstN), .csN(csN), .ioClk(ioClk),
    .stb(stb), .csActive(csActive), .sampleEn(sampleEn), .holdEn(holdEn)
  );

  sadc_dp #(.RES_W(RES_W)) dpI (
    .clk(clk), .rstN(rstN), .stb(stb), .cmpIn(cmpIn), .testSel(testSel),
    .testCode(testCode), .serBit(serBit), .sarTrial(sarTrial),
    .convDone(convDone)
  );

  // Release follows the raw pin so a deselect frees the line at once.
  assign serDrive = csActive & ~csN;
  assign serData  = serDrive ? serBit : 1'bz;

endmodule

// File: rtl/sadc_serial_ctrl_chk.sv
module sadc_serial_ctrl_chk #(
  parameter int RES_W = 8
) (
  input logic             clk,
  input logic             rstN,
  input logic             csN,
  input logic             serDrive,
  input logic [RES_W-1:0] sarTrial,
  input logic             sampleEn,
  input logic             holdEn,
  input logic             convDone
);

  // R3
  release_on_deselect_chk: assert property (@(posedge clk) disable iff (!rstN)
    csN |-> !serDrive);

  // R6
  hold_no_sample_chk: assert property (@(posedge clk) disable iff (!rstN)
    holdEn |-> !sampleEn);

  // R6
  hold_no_trial_chk: assert property (@(posedge clk) disable iff (!rstN)
    holdEn |-> (sarTrial == '0));

  // R8
  done_single_chk: assert property (@(posedge clk) disable iff (!rstN)
    convDone |=> !convDone);

  // R5
  sample_before_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(holdEn) |-> $past(sampleEn));

  // R8
  done_not_in_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({holdEn, convDone}));

endmodule

bind sadc_serial_ctrl sadc_serial_ctrl_chk #(.RES_W(RES_W)) chk_i (
  .clk(clk), .rstN(rstN), .csN(csN), .serDrive(serDrive), .sarTrial(sarTrial),
  .sampleEn(sampleEn), .holdEn(holdEn), .convDone(convDone)
);

// File: tb/sadc_serial_ctrl_tb_top.sv
module sadc_serial_ctrl_tb_top;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       csN = 1'b1;
  logic       ioClk = 1'b0;
  logic       testSel = 1'b0;
  logic [7:0] testCode = 8'h00;
  logic [7:0] analogVal = 8'h00;
  logic       cmpIn;
  wire        serData;
  logic       serDrive, sampleEn, holdEn, convDone;
  logic [7:0] sarTrial;

  int checks = 0;
  int failures = 0;
  int doneCount = 0;
  int cycles = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  // Behavioural comparator against the analog level
  assign cmpIn = (sarTrial <= analogVal);

  sadc_serial_ctrl dut_i (
    .clk(clk), .rstN(rstN), .csN(csN), .ioClk(ioClk), .cmpIn(cmpIn),
    .testSel(testSel), .testCode(testCode), .serData(serData),
    .serDrive(serDrive), .sarTrial(sarTrial), .sampleEn(sampleEn),
    .holdEn(holdEn), .convDone(convDone)
  );

  task automatic chk(bit ok, string tag, int act, int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // ---------------- reference model ----------------
  int csQ[$];
  int ioQ[$];
  int mAct, mRun, mEdge, mSamp, mPhase, mCnt, mShift, mResult, mDone;

  task automatic modelReset();
    csQ = {1, 1, 1, 1};
    ioQ = {0, 0, 0, 0};
    mAct = 0; mRun = 0; mEdge = 0; mSamp = 0; mPhase = 0; mCnt = 0;
    mShift = 0; mResult = 0; mDone = 0;
  endtask

  initial modelReset();

  always @(posedge clk) begin
    if (!rstN) begin
      modelReset();
    end else begin
      bit sel, fall, start, frameEnd, abort;
      csQ.push_front(int'(csN)); void'(csQ.pop_back());
      ioQ.push_front(int'(ioClk)); void'(ioQ.pop_back());
      sel      = (csQ[2] == 0);
      fall     = (ioQ[3] == 1) && (ioQ[2] == 0);
      start    = sel && !mAct && (mRun == 2);
      frameEnd = sel && mAct && fall && (mEdge == 7);
      abort    = start || frameEnd;
      mDone    = 0;
      if (!abort) begin
        if (mPhase == 1) begin
          if (mCnt == 3) begin mPhase = 2; mCnt = 0; end else mCnt++;
        end else if (mPhase == 2) begin
          if (mCnt == 31) begin
            mPhase = 0; mCnt = 0; mDone = 1;
            mResult = testSel ? int'(testCode) : int'(analogVal);
          end else mCnt++;
        end
      end
      if (!sel) begin
        mAct = 0; mRun = 0; mEdge = 0; mSamp = 0;
      end else if (!mAct) begin
        if (mRun == 2) begin
          mAct = 1; mEdge = 0; mSamp = 0; mPhase = 0; mCnt = 0; mShift = mResult;
        end else mRun++;
      end else if (fall) begin
        if (mEdge == 7) begin
          mEdge = 0; mSamp = 0; mPhase = 1; mCnt = 0; mShift = mResult;
        end else begin
          mEdge++;
          mShift = (mShift << 1) & 8'hFF;
          if (mEdge == 4) mSamp = 1;
        end
      end else if (mDone == 1 && mEdge == 0) begin
        mShift = mResult;
      end
    end
    #5;
    begin
      int expDrive;
      expDrive = (mAct == 1 && csN == 1'b0) ? 1 : 0;
      // R1 R3 R11: drive state
      chk(int'(serDrive) == expDrive, "R3 serDrive", int'(serDrive), expDrive);
      // R4 R10: serial bit
      if (expDrive == 1)
        chk(int'(serData) == ((mShift >> 7) & 1), "R4 serData", int'(serData), (mShift >> 7) & 1);
      // R5
      chk(int'(sampleEn) == mSamp, "R5 sampleEn", int'(sampleEn), mSamp);
      // R6
      chk(int'(holdEn) == ((mPhase == 1) ? 1 : 0), "R6 holdEn", int'(holdEn), (mPhase == 1) ? 1 : 0);
      // R8 R9
      chk(int'(convDone) == mDone, "R8 convDone", int'(convDone), mDone);
    end
  end

  always @(posedge clk) if (convDone) doneCount++;

  // ---------------- watchdog ----------------
  always @(posedge clk) begin
    cycles++;
    if (cycles > 60000 && !finished) begin
      finished = 1;
      failures++;
      $display("FAIL watchdog actual=%0d expected=%0d", cycles, 60000);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  // ---------------- stimulus ----------------
  task automatic tick(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse(int half);
    ioClk = 1'b1; tick(half);
    ioClk = 1'b0; tick(half);
  endtask

  task automatic readFrame(bit lowerCs, output logic [7:0] v);
    if (lowerCs) begin csN = 1'b0; tick(8); end
    for (int i = 0; i < 8; i++) begin
      v[7-i] = serData;
      pulse(4);
    end
  endtask

  task automatic fastFrame();
    for (int i = 0; i < 8; i++) pulse(1);
  endtask

  initial begin
    logic [7:0] got;
    int d0;
    tick(3);
    rstN = 1'b1;
    tick(2);
    // R11: reset state
    chk(serDrive == 1'b0 && sampleEn == 1'b0 && holdEn == 1'b0 && convDone == 1'b0,
        "R11 idle after reset", int'({serDrive, sampleEn, holdEn, convDone}), 0);

    // R1: I/O clock ignored while deselected
    for (int i = 0; i < 10; i++) pulse(2);
    tick(40);
    chk(doneCount == 0, "R1 no conversion while deselected", doneCount, 0);
    chk(holdEn == 1'b0 && sampleEn == 1'b0, "R1 strobes idle", int'({holdEn, sampleEn}), 0);

    // R7 test register mode, R11 first result
    testSel = 1'b1; testCode = 8'hA5;
    readFrame(1, got);
    chk(got == 8'h00, "R11 reset result read", int'(got), 8'h00);
    tick(60);
    chk(doneCount == 1, "R8 one completion", doneCount, 1);
    csN = 1'b1; tick(6);
    readFrame(1, got);
    chk(got == 8'hA5, "R7 test code result", int'(got), 8'hA5);
    tick(60); csN = 1'b1; tick(6);

    // R7 comparator mode
    testSel = 1'b0; analogVal = 8'h3C;
    readFrame(1, got);
    chk(got == 8'hA5, "R4 previous result", int'(got), 8'hA5);
    tick(60); csN = 1'b1; tick(6);

    // R9 cancel by new select
    analogVal = 8'h81;
    d0 = doneCount;
    readFrame(1, got);
    chk(got == 8'h3C, "R7 comparator result", int'(got), 8'h3C);
    csN = 1'b1; tick(5);
    readFrame(1, got);
    chk(got == 8'h3C, "R9 result kept after cancel", int'(got), 8'h3C);
    chk(doneCount == d0, "R9 no done for cancelled", doneCount, d0);
    tick(60); csN = 1'b1; tick(6);

    // R10 select held low across frames
    analogVal = 8'h5A;
    readFrame(1, got);
    chk(got == 8'h81, "R10 first frame", int'(got), 8'h81);
    tick(60);
    analogVal = 8'hC3;
    d0 = doneCount;
    readFrame(0, got);
    chk(got == 8'h5A, "R10 refreshed while low", int'(got), 8'h5A);
    analogVal = 8'h77;
    fastFrame();
    tick(60);
    chk(doneCount == d0 + 1, "R9 frame cancels conversion", doneCount, d0 + 1);
    csN = 1'b1; tick(6);

    // R2 short select pulse ignored
    analogVal = 8'h12;
    readFrame(1, got);
    chk(got == 8'h77, "R10 fast frame result", int'(got), 8'h77);
    csN = 1'b1; tick(3);
    d0 = doneCount;
    csN = 1'b0; tick(1); csN = 1'b1;
    tick(60);
    chk(doneCount == d0 + 1, "R2 glitch does not cancel", doneCount, d0 + 1);

    // R3 release mid-frame, then a fresh frame
    csN = 1'b0; tick(8);
    for (int i = 0; i < 3; i++) pulse(4);
    csN = 1'b1;
    #1;
    chk(serDrive == 1'b0, "R3 immediate release", int'(serDrive), 0);
    tick(10);
    readFrame(1, got);
    chk(got == 8'h12, "R4 frame restarts at MSB", int'(got), 8'h12);
    tick(60); csN = 1'b1; tick(6);

    if (!finished) begin
      finished = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule